// File: doc/BRIEF.md
# Three-Phase Commutation and Bridge Drive Logic

This block turns the three digitized Hall comparator levels of a brushless motor into gate commands for a three-phase bridge: one upper (source) switch and one lower (sink) switch at a time. The six valid Hall states each select one source/sink pair. Reverse rotation reuses the same six pairs, reached through the bitwise complement of the Hall code. The two codes that no healthy sensor set produces turn the bridge off.

Speed regulation happens outside the block. An external PWM generator supplies a per-cycle on/off level and a cycle-start pulse, and the block applies that level to the lower switches. An over-current flag cuts the lower switches for the rest of the current PWM cycle. Stop, short braking (all upper switches on, all lower off, with no current limiting) and a protection shutdown that removes all upper drive sit above commutation in a fixed priority. A direction change holds the bridge off for a parameterized number of clocks before the new mapping takes effect. All six outputs are registered, so each one reflects the inputs sampled at the previous rising clock edge.

Top module: `bldc_commutator`

## Requirements
- R1: With `dir_rev` low, the code {hall_in[2],hall_in[1],hall_in[0]} maps to (source, sink) as 101→(V,U), 100→(W,U), 110→(W,V), 010→(U,V), 011→(U,W), 001→(V,W). Outputs update one clock after the inputs are sampled.
- R2: With `dir_rev` high, the block produces the pair that R1 gives for the bitwise complement of the Hall code. For example, 010 gives (V,U).
- R3: Hall codes 000 and 111 drive all six outputs low while running.
- R4: `stop_req` high drives all six outputs low, whatever the other inputs are.
- R5: With `stop_req` low and `brake_req` high, all three upper outputs are high and all three lower outputs are low. Hall code, `pwm_on`, `ilim_flag` and the direction hold have no effect in this state.
- R6: `prot_off` high forces all three upper outputs low in every state. The lower outputs keep the value they would otherwise have.
- R7: While running, the selected lower output equals `pwm_on`. The selected upper output stays high whatever `pwm_on` is.
- R8: `ilim_flag` high turns the lower outputs off from the next update onward. They stay off after the flag drops, until a `pwm_sync` pulse that coincides with a low flag, which re-enables them in that same update.
- R9: A change of `dir_rev` holds all outputs low for GUARD_CYCLES+1 updates. The new mapping appears at the next update. During reset the applied direction follows `dir_rev`, so leaving reset starts no hold.
- R10: While `rst_n` is low at a clock edge, all outputs become low.
- R11: Outside braking, at most one upper and at most one lower output is high. Upper and lower outputs of the same phase are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hall_in | input | 3 | Hall levels, bit 2 = sensor 1, bit 0 = sensor 3 |
| dir_rev | input | 1 | 0 forward, 1 reverse |
| brake_req | input | 1 | 1 requests short braking |
| stop_req | input | 1 | 1 stops (all off), 0 runs |
| pwm_on | input | 1 | PWM on-level for lower switches |
| pwm_sync | input | 1 | One-clock pulse at each PWM cycle start |
| ilim_flag | input | 1 | Over-current flag |
| prot_off | input | 1 | Protection shutdown of upper switches |
| hs_u | output | 1 | Upper switch, phase U |
| hs_v | output | 1 | Upper switch, phase V |
| hs_w | output | 1 | Upper switch, phase W |
| ls_u | output | 1 | Lower switch, phase U |
| ls_v | output | 1 | Lower switch, phase V |
| ls_w | output | 1 | Lower switch, phase W |

## Verification
The hardest situation to reach is the exact end of the direction-change hold, because it depends on a counter that the ports never show. The stimulus flips `dir_rev` on a steady valid Hall code and samples every update through the hold window. It expects zeros for GUARD_CYCLES+1 updates and then the complemented-code pair. The over-current latch is also hard to reach, because it stays invisible once the flag drops. The bench clears the flag and waits several clocks with no sync pulse, confirming the lower output stays off, and only then issues `pwm_sync`.

// File: rtl/comm_pkg.sv
// Shared types and the forward commutation table for the bridge drive logic.
// Assumes phase vectors are ordered bit0 = U, bit1 = V, bit2 = W.
package comm_pkg;

    localparam int PHASES = 3;

    typedef logic [PHASES-1:0] phase_vec_t;

    typedef struct packed {
        logic       valid;
        phase_vec_t src;
        phase_vec_t snk;
    } drive_pair_t;

    localparam phase_vec_t PH_U = 3'b001;
    localparam phase_vec_t PH_V = 3'b010;
    localparam phase_vec_t PH_W = 3'b100;

    // Forward-direction lookup: Hall code {s1,s2,s3} to source/sink phases.
    function automatic drive_pair_t fwd_lookup(input logic [2:0] code);
        drive_pair_t r;
        r = '{valid: 1'b0, src: '0, snk: '0};
        case (code)
            3'b101: r = '{valid: 1'b1, src: PH_V, snk: PH_U};
            3'b100: r = '{valid: 1'b1, src: PH_W, snk: PH_U};
            3'b110: r = '{valid: 1'b1, src: PH_W, snk: PH_V};
            3'b010: r = '{valid: 1'b1, src: PH_U, snk: PH_V};
            3'b011: r = '{valid: 1'b1, src: PH_U, snk: PH_W};
            3'b001: r = '{valid: 1'b1, src: PH_V, snk: PH_W};
            default: r = '{valid: 1'b0, src: '0, snk: '0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/comm_hall_decode.sv
// Hall decoder: maps the Hall code and the applied direction to one source
// and one sink phase. Reverse uses the complemented code on the same table.
// Assumes hall_in is already synchronized and debounced upstream.
module comm_hall_decode
    import comm_pkg::*;
(
    input  logic [2:0]  hall_in,
    input  logic        dir_rev,
    output drive_pair_t pair
);

    logic [2:0] code;

    // Select the table index for the applied direction.
    always_comb begin
        code = dir_rev ? ~hall_in : hall_in;
        pair = fwd_lookup(code);
    end

endmodule

// File: rtl/comm_dir_guard.sv
// Direction guard: remembers the applied direction and, on any change,
// raises a hold for GUARD_CYCLES+1 clocks (the detection clock included).
// During reset the applied direction tracks the input so that no hold
// starts when reset is released.
module comm_dir_guard #(
    parameter int GUARD_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_in,
    output logic dir_applied,
    output logic hold
);

    localparam int CW = (GUARD_CYCLES < 1) ? 1 : $clog2(GUARD_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(GUARD_CYCLES);

    logic          dir_q;
    logic [CW-1:0] cnt_q;
    logic          change;

    // Detect a direction edge against the applied value.
    always_comb begin
        change = (dir_in != dir_q);
        hold   = change || (cnt_q != '0);
    end

    // Update the applied direction and the hold counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= dir_in;
            cnt_q <= '0;
        end else if (change) begin
            dir_q <= dir_in;
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign dir_applied = dir_q;

endmodule

// File: rtl/comm_ilim_gate.sv
// Current-limit gate: once the over-current flag is seen, blocks the lower
// switches until the next PWM cycle start with the flag low.
// Assumes pwm_sync is a single-clock pulse from the PWM generator.
module comm_ilim_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ilim_flag,
    input  logic pwm_sync,
    output logic block
);

    logic latch_q;

    // Block on the flag, or on an earlier hit not yet re-armed by sync.
    always_comb begin
        block = ilim_flag || (latch_q && !pwm_sync);
    end

    // Remember the block state for the remainder of the PWM cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
        end else begin
            latch_q <= block;
        end
    end

endmodule

// File: rtl/bldc_commutator.sv
// Three-phase commutation and bridge drive logic.
// Priority: stop > brake > direction hold > invalid Hall > commutation.
// The protection shutdown masks the upper switches in every state.
// PWM and current limit act on the lower switches only; braking bypasses them.
// All outputs are registered; synchronous active-low reset clears them.
module bldc_commutator
    import comm_pkg::*;
#(
    parameter int GUARD_CYCLES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_in,
    input  logic       dir_rev,
    input  logic       brake_req,
    input  logic       stop_req,
    input  logic       pwm_on,
    input  logic       pwm_sync,
    input  logic       ilim_flag,
    input  logic       prot_off,
    output logic       hs_u,
    output logic       hs_v,
    output logic       hs_w,
    output logic       ls_u,
    output logic       ls_v,
    output logic       ls_w
);

    drive_pair_t pair;
    logic        dir_applied;
    logic        hold;
    logic        ilim_block;
    phase_vec_t  lo_gated;
    phase_vec_t  hi_next;
    phase_vec_t  lo_next;
    phase_vec_t  hi_q;
    phase_vec_t  lo_q;

    comm_dir_guard #(
        .GUARD_CYCLES(GUARD_CYCLES)
    ) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_in     (dir_rev),
        .dir_applied(dir_applied),
        .hold       (hold)
    );

    comm_hall_decode u_decode (
        .hall_in(hall_in),
        .dir_rev(dir_applied),
        .pair   (pair)
    );

    comm_ilim_gate u_ilim (
        .clk      (clk),
        .rst_n    (rst_n),
        .ilim_flag(ilim_flag),
        .pwm_sync (pwm_sync),
        .block    (ilim_block)
    );

    // Per-phase lower-switch gating by PWM level and current limit.
    for (genvar p = 0; p < PHASES; p++) begin : g_lo_gate
        assign lo_gated[p] = pair.snk[p] && pwm_on && !ilim_block;
    end

    // Resolve the operating state into next upper/lower commands.
    always_comb begin
        hi_next = '0;
        lo_next = '0;
        if (stop_req) begin
            hi_next = '0;
            lo_next = '0;
        end else if (brake_req) begin
            hi_next = '1;
            lo_next = '0;
        end else if (!hold && pair.valid) begin
            hi_next = pair.src;
            lo_next = lo_gated;
        end
        if (prot_off) begin
            hi_next = '0;
        end
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            hi_q <= hi_next;
            lo_q <= lo_next;
        end
    end

    assign hs_u = hi_q[0];
    assign hs_v = hi_q[1];
    assign hs_w = hi_q[2];
    assign ls_u = lo_q[0];
    assign ls_v = lo_q[1];
    assign ls_w = lo_q[2];

endmodule

// File: rtl/comm_checker.sv
// Property checker for bldc_commutator, attached through bind.
// Relates sampled inputs to the registered outputs one clock later.
module comm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] hall_in,
    input logic       dir_rev,
    input logic       brake_req,
    input logic       stop_req,
    input logic       ilim_flag,
    input logic       prot_off,
    input logic       hs_u,
    input logic       hs_v,
    input logic       hs_w,
    input logic       ls_u,
    input logic       ls_v,
    input logic       ls_w
);

    logic [2:0] hs;
    logic [2:0] ls;
    assign hs = {hs_w, hs_v, hs_u};
    assign ls = {ls_w, ls_v, ls_u};

    // Stop clears everything.
    assert_stop_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (hs == 3'b000 && ls == 3'b000));

    // Braking drives all upper switches at full duty.
    assert_brake_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_req && brake_req && !prot_off) |=> (hs == 3'b111 && ls == 3'b000));

    // Protection removes upper drive.
    assert_prot_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prot_off |=> (hs == 3'b000));

    // Over-current flag cuts the lower switches.
    assert_ilim_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_flag |=> (ls == 3'b000));

    // Invalid Hall codes give an idle bridge.
    assert_bad_hall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_req && !brake_req && (hall_in == 3'b000 || hall_in == 3'b111))
        |=> (hs == 3'b000 && ls == 3'b000));

    // A direction edge starts the hold at the next update.
    assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_req && !brake_req && (dir_rev != $past(dir_rev)))
        |=> (hs == 3'b000 && ls == 3'b000));

    // Outside braking, at most one switch per side.
    assert_one_hot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !brake_req |=> ($onehot0(hs) && $onehot0(ls)));

    // No phase has both switches on.
    assert_no_shoot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hs & ls) == 3'b000);

    // Reset clears the outputs.
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (hs == 3'b000 && ls == 3'b000));

endmodule

bind bldc_commutator comm_checker u_comm_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .hall_in  (hall_in),
    .dir_rev  (dir_rev),
    .brake_req(brake_req),
    .stop_req (stop_req),
    .ilim_flag(ilim_flag),
    .prot_off (prot_off),
    .hs_u     (hs_u),
    .hs_v     (hs_v),
    .hs_w     (hs_w),
    .ls_u     (ls_u),
    .ls_v     (ls_v),
    .ls_w     (ls_w)
);

// File: tb/test_bldc_commutator.sv
// Self-checking bench: sweeps Hall code x direction x PWM level, then walks
// the priority states, the current-limit latch and the direction hold.
module test_bldc_commutator;

    localparam int G = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_in = 3'b101;
    logic       dir_rev = 1'b0;
    logic       brake_req = 1'b0;
    logic       stop_req = 1'b0;
    logic       pwm_on = 1'b1;
    logic       pwm_sync = 1'b0;
    logic       ilim_flag = 1'b0;
    logic       prot_off = 1'b0;
    logic       hs_u, hs_v, hs_w, ls_u, ls_v, ls_w;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bldc_commutator #(.GUARD_CYCLES(G)) i_bldc_commutator (
        .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .dir_rev(dir_rev),
        .brake_req(brake_req), .stop_req(stop_req), .pwm_on(pwm_on),
        .pwm_sync(pwm_sync), .ilim_flag(ilim_flag), .prot_off(prot_off),
        .hs_u(hs_u), .hs_v(hs_v), .hs_w(hs_w),
        .ls_u(ls_u), .ls_v(ls_v), .ls_w(ls_w)
    );

    // Expected {src[2:0], snk[2:0]} (bit0 = U) from the forward table.
    function automatic logic [5:0] fwd_exp(input logic [2:0] c);
        case (c)
            3'b101: return {3'b010, 3'b001};
            3'b100: return {3'b100, 3'b001};
            3'b110: return {3'b100, 3'b010};
            3'b010: return {3'b001, 3'b010};
            3'b011: return {3'b001, 3'b100};
            3'b001: return {3'b010, 3'b100};
            default: return 6'b0;
        endcase
    endfunction

    function automatic logic [5:0] run_exp(input logic [2:0] h, input logic d, input logic p);
        logic [5:0] e;
        e = fwd_exp(d ? ~h : h);
        if (!p) e[2:0] = 3'b000;
        return e;
    endfunction

    task automatic check(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {hs_w, hs_v, hs_u, ls_w, ls_v, ls_u};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual hs/ls=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) step();
        check("R10 reset", 6'b0);
        rst_n = 1'b1;
        step();

        // R1 R2 R3 R7: full sweep, waiting out the hold after each dir change.
        for (int d = 0; d < 2; d++) begin
            dir_rev = d[0];
            repeat (G + 3) step();
            for (int h = 0; h < 8; h++) begin
                for (int p = 0; p < 2; p++) begin
                    hall_in = h[2:0];
                    pwm_on = p[0];
                    step();
                    if (h == 0 || h == 7) check("R3 invalid hall", 6'b0);
                    else if (d == 0) check("R1 forward map / R7 pwm", run_exp(h[2:0], 1'b0, p[0]));
                    else check("R2 reverse map / R7 pwm", run_exp(h[2:0], 1'b1, p[0]));
                end
            end
        end
        hall_in = 3'b010; pwm_on = 1'b1;
        step();
        check("R2 reverse 010 gives V,U", {3'b010, 3'b001});

        // R9: reverse -> forward on a steady code, count the hold.
        dir_rev = 1'b0;
        for (int k = 0; k < G + 1; k++) begin
            step();
            check("R9 direction hold", 6'b0);
        end
        step();
        check("R9 new mapping after hold", run_exp(3'b010, 1'b0, 1'b1));

        // R4: stop overrides brake and commutation.
        stop_req = 1'b1; brake_req = 1'b1;
        step();
        check("R4 stop", 6'b0);
        stop_req = 1'b0; brake_req = 1'b0;
        step();

        // R5: brake ignores hall, pwm, current limit.
        brake_req = 1'b1; hall_in = 3'b000; pwm_on = 1'b0; ilim_flag = 1'b1;
        step();
        check("R5 brake full upper", {3'b111, 3'b000});
        hall_in = 3'b011; pwm_on = 1'b1;
        step();
        check("R5 brake holds", {3'b111, 3'b000});

        // R6: protection during brake and during run.
        prot_off = 1'b1;
        step();
        check("R6 prot in brake", 6'b0);
        brake_req = 1'b0; ilim_flag = 1'b0; pwm_sync = 1'b1;
        step();
        pwm_sync = 1'b0;
        step();
        check("R6 prot in run keeps lower", {3'b000, run_exp(3'b011, 1'b0, 1'b1)}[5:0] & 6'b000111);
        prot_off = 1'b0;
        step();
        check("R6 released", run_exp(3'b011, 1'b0, 1'b1));

        // R8: latch until sync.
        ilim_flag = 1'b1;
        step();
        check("R8 limit cuts lower", {run_exp(3'b011, 1'b0, 1'b1)[5:3], 3'b000});
        ilim_flag = 1'b0;
        repeat (3) begin
            step();
            check("R8 latched after flag drop", {run_exp(3'b011, 1'b0, 1'b1)[5:3], 3'b000});
        end
        pwm_sync = 1'b1;
        step();
        pwm_sync = 1'b0;
        check("R8 re-armed by sync", run_exp(3'b011, 1'b0, 1'b1));

        // R9 forward -> reverse with hall stepping during hold.
        dir_rev = 1'b1;
        step();
        check("R9 hold starts", 6'b0);
        hall_in = 3'b101;
        repeat (G) begin
            step();
            check("R9 hold continues", 6'b0);
        end
        step();
        check("R9 reverse applied", run_exp(3'b101, 1'b1, 1'b1));

        // R10: reset mid-run clears outputs.
        rst_n = 1'b0;
        step();
        check("R10 reset in run", 6'b0);
        rst_n = 1'b1;
        step();
        check("R9 no hold after reset", run_exp(3'b101, 1'b1, 1'b1));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule